// File: doc/BRIEF.md
# Serial Address-Mark Window Generator

This block raises an address-mark enable during selected bit times of each byte sent on a serial write data path. A host loads an 8-bit mask. A bit-position counter follows the serial stream. The enable is asserted for a bit only when two things hold: the mask selects that bit's position, and the sequencer instruction now executing requests an address mark. When the request flag is low, the enable is low, whatever the mask holds.

The serial stream is described by three inputs. A bit strobe marks each bit time. A byte-start flag marks the first bit of a byte. Bits go out most significant first, so serial bit 7 is the first bit of each byte. Mask bits run in the opposite order to bus numbering: mask bit 0 selects serial bit 7, and mask bit 7 selects serial bit 0. The enable is registered and changes only on a bit strobe, so it stays aligned with the bit it marks. The mask has no reset and keeps its contents through reset.

Top module: `am_window_gen`

## Requirements
- R1: When `host_wr_i` is high at a clock edge, the mask takes `host_wdata_i`. From the next cycle, `host_rdata_o` returns that value unchanged, in the same reversed bit order.
- R2: Asserting `rst_ni` leaves the mask unchanged. Only a host write alters it.
- R3: On a strobe (`bit_en_i` high) with `byte_start_i` high, the current bit is serial bit 7. Each strobe without `byte_start_i` moves to the next lower bit, and after bit 0 the position wraps to bit 7. A `byte_start_i` in the middle of a byte restarts the position at bit 7.
- R4: After each strobe, `am_en_o` equals `am_req_i & mask[7-b]`, where b is the serial bit index of that strobe. For example, a mask of 0x01 enables only serial bit 7.
- R5: A strobe taken while `am_req_i` is low drives `am_en_o` low, whatever the mask holds.
- R6: `am_en_o` changes only at a clock edge where `bit_en_i` is high. Between strobes it holds its value, even across mask writes.
- R7: While `rst_ni` is low, `am_en_o` is low. The first strobe after reset is treated as serial bit 7.
- R8: If `am_req_i` falls in the middle of a byte, `am_en_o` goes low at the next bit time, and the remaining bits of that byte stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the mask |
| host_wdata_i | input | 8 | Mask value to write (bit 0 selects serial bit 7) |
| host_rdata_o | output | 8 | Current mask value |
| bit_en_i | input | 1 | Serial bit-time strobe, one cycle per bit |
| byte_start_i | input | 1 | High together with the strobe of the first bit of a byte |
| am_req_i | input | 1 | Address-mark request from the current instruction |
| am_en_o | output | 1 | Registered address-mark enable |

## Verification
The assertions assume that `byte_start_i` only has meaning in a cycle where `bit_en_i` is high. They also assume that `am_req_i` and `bit_en_i` are settled before the clock edge that samples them, as the serializer and sequencer around the block guarantee. The bench drives every input on the falling clock edge and raises `byte_start_i` only together with a strobe. It keeps its own model of the bit position from R3 and does not rely on any internal counter. The mask has no reset, so the bench always writes it before the first strobe whose result it checks.

// File: rtl/am_window_pkg.sv
package am_window_pkg;
  localparam int unsigned AM_BITS  = 8;
  localparam int unsigned AM_POS_W = $clog2(AM_BITS);
  typedef logic [AM_BITS-1:0]  am_mask_t;
  typedef logic [AM_POS_W-1:0] am_pos_t;
  // first serial bit of a byte (msb first)
  localparam am_pos_t AM_FIRST_POS = am_pos_t'(AM_BITS - 1);
endpackage

// File: rtl/am_mask_reg.sv
module am_mask_reg
  import am_window_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  am_mask_t wdata_i,
  output am_mask_t mask_o
);
  am_mask_t mask_q;

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  p_wr_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mask_o == $past(wdata_i));

  p_mask_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && $past(rst_ni)) |=> $stable(mask_o));
endmodule

// File: rtl/am_bit_pos.sv
module am_bit_pos
  import am_window_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bit_en_i,
  input  logic    byte_start_i,
  output am_pos_t cur_pos_o
);
  am_pos_t next_q;

  assign cur_pos_o = byte_start_i ? AM_FIRST_POS : next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       next_q <= AM_FIRST_POS;
    else if (bit_en_i) next_q <= cur_pos_o - am_pos_t'(1);
  end

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && byte_start_i) |=> next_q == am_pos_t'(AM_BITS - 2));

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !byte_start_i) |=> next_q == am_pos_t'($past(next_q) - am_pos_t'(1)));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(next_q));
endmodule

// File: rtl/am_gate.sv
module am_gate
  import am_window_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  logic     am_req_i,
  input  am_mask_t mask_i,
  input  am_pos_t  cur_pos_i,
  output logic     am_en_o
);
  am_mask_t by_pos;
  logic     am_en_q;

  // mask bit 0 maps to serial bit AM_BITS-1
  for (genvar p = 0; p < AM_BITS; p++) begin : g_rev
    assign by_pos[p] = mask_i[AM_BITS-1-p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       am_en_q <= 1'b0;
    else if (bit_en_i) am_en_q <= am_req_i & by_pos[cur_pos_i];
  end

  assign am_en_o = am_en_q;

  p_req_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !am_req_i) |=> !am_en_o);

  p_hold_between_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(am_en_o));

  p_first_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && am_req_i && cur_pos_i == AM_FIRST_POS) |=> am_en_o == $past(mask_i[0]));
endmodule

// File: rtl/am_window_gen.sv
module am_window_gen
  import am_window_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic [AM_BITS-1:0]  host_wdata_i,
  output logic [AM_BITS-1:0]  host_rdata_o,
  input  logic                bit_en_i,
  input  logic                byte_start_i,
  input  logic                am_req_i,
  output logic                am_en_o
);
  am_mask_t mask;
  am_pos_t  cur_pos;

  am_mask_reg u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (host_wr_i),
    .wdata_i (host_wdata_i),
    .mask_o  (mask)
  );

  am_bit_pos u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .byte_start_i (byte_start_i),
    .cur_pos_o    (cur_pos)
  );

  am_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .am_req_i  (am_req_i),
    .mask_i    (mask),
    .cur_pos_i (cur_pos),
    .am_en_o   (am_en_o)
  );

  assign host_rdata_o = mask;

  p_reset_low_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !am_en_o);

  p_start_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && byte_start_i) |=> am_en_o == ($past(am_req_i) & $past(host_rdata_o[0])));
endmodule

// File: tb/am_window_gen_tb_top.sv
module am_window_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bit_en = 1'b0;
  logic       bstart = 1'b0;
  logic       req = 1'b0;
  logic       am_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] m_model = '0;
  int pos = 7;

  always #4 clk = ~clk;  // 125 MHz

  am_window_gen dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_wr_i    (wr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .bit_en_i     (bit_en),
    .byte_start_i (bstart),
    .am_req_i     (req),
    .am_en_o      (am_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    tick();
    wr = 1'b0;
    m_model = v;
  endtask

  // one strobe; bench tracks serial position per R3
  task automatic strobe(input logic bs, input logic rq, input string tag);
    int cur;
    logic exp;
    bit_en = 1'b1; bstart = bs; req = rq;
    tick();
    bit_en = 1'b0; bstart = 1'b0;
    cur = bs ? 7 : pos;
    pos = (cur + 7) % 8;
    exp = rq & m_model[7-cur];
    check(am_en === exp, tag, int'(am_en), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    check(am_en === 1'b0, "R7 enable low in reset", int'(am_en), 0);
    rst_n = 1'b1;
    pos = 7;
    tick();
  endtask

  task automatic t_reset_state();
    do_reset();
    check(am_en === 1'b0, "R7 enable low after reset", int'(am_en), 0);
  endtask

  task automatic t_write_read();
    host_write(8'hA5);
    check(rdata === 8'hA5, "R1 readback", int'(rdata), 'hA5);
    host_write(8'h3C);
    check(rdata === 8'h3C, "R1 readback second", int'(rdata), 'h3C);
  endtask

  task automatic t_first_bit_only();
    host_write(8'h01);
    strobe(1'b1, 1'b1, "R4 mask 0x01 serial bit 7");
    for (int i = 0; i < 7; i++) strobe(1'b0, 1'b1, "R4 mask 0x01 other bits low");
  endtask

  task automatic t_patterns();
    logic [7:0] pats [4] = '{8'h80, 8'h3C, 8'hFF, 8'h5A};
    foreach (pats[k]) begin
      host_write(pats[k]);
      strobe(1'b1, 1'b1, "R4 pattern bit");
      for (int i = 0; i < 7; i++) strobe(1'b0, 1'b1, "R4 pattern bit");
    end
  endtask

  task automatic t_req_low();
    host_write(8'hFF);
    strobe(1'b1, 1'b0, "R5 request low");
    for (int i = 0; i < 7; i++) strobe(1'b0, 1'b0, "R5 request low");
  endtask

  task automatic t_mid_drop();
    host_write(8'hFF);
    strobe(1'b1, 1'b1, "R8 before drop");
    strobe(1'b0, 1'b1, "R8 before drop");
    strobe(1'b0, 1'b1, "R8 before drop");
    for (int i = 0; i < 5; i++) strobe(1'b0, 1'b0, "R8 after drop");
  endtask

  task automatic t_hold();
    host_write(8'h01);
    strobe(1'b1, 1'b1, "R6 setup high");
    req = 1'b0;
    host_write(8'h00);
    repeat (3) tick();
    check(am_en === 1'b1, "R6 hold across idle and write", int'(am_en), 1);
    strobe(1'b0, 1'b1, "R6 update on strobe");
  endtask

  task automatic t_wrap_resync();
    host_write(8'h01);
    strobe(1'b1, 1'b1, "R3 byte start");
    for (int i = 0; i < 7; i++) strobe(1'b0, 1'b1, "R3 descend");
    strobe(1'b0, 1'b1, "R3 wrap to bit 7");
    check(am_en === 1'b1, "R3 wrap marks bit 7", int'(am_en), 1);
    strobe(1'b0, 1'b1, "R3 after wrap");
    strobe(1'b0, 1'b1, "R3 after wrap");
    strobe(1'b1, 1'b1, "R3 mid-byte restart");
    check(am_en === 1'b1, "R3 restart marks bit 7", int'(am_en), 1);
    host_write(8'h02);
    strobe(1'b0, 1'b1, "R3 bit 6 after restart");
    check(am_en === 1'b1, "R3 bit 6 via mask bit 1", int'(am_en), 1);
  endtask

  task automatic t_reset_keep();
    host_write(8'h69);
    do_reset();
    check(rdata === 8'h69, "R2 mask kept through reset", int'(rdata), 'h69);
    host_write(8'h01);
    strobe(1'b0, 1'b1, "R7 first strobe after reset is bit 7");
    check(am_en === 1'b1, "R7 first strobe marks bit 7", int'(am_en), 1);
  endtask

  initial begin
    t_reset_state();
    t_write_read();
    t_first_bit_only();
    t_patterns();
    t_req_low();
    t_mid_drop();
    t_hold();
    t_wrap_resync();
    t_reset_keep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule